// File: doc/BRIEF.md
# Multichannel SPI Channel Controller

This block is the sequencing core of a four-channel SPI master. It keeps each channel's configuration word, enable bit, transmit and receive data words and three status flags. It decides when a word exchange may begin on a channel, and it hands that exchange to an external serial shifter over a start/done handshake. When the shifter reports completion, the block updates the channel's flags.

Software-side accesses reach the block as simple strobes: a configuration write, an enable write, a transmit-word write and a receive-word read, each with a channel index. Any of three events asks for a start check on a channel: a transmit write, a receive read, or the enable going from 0 to 1. The check is held while another exchange is in flight. Per-channel transmit and receive DMA requests come straight from the flags. One-cycle event pulses mark a completed exchange, for an interrupt collector elsewhere.

Top module: `mspi_chan_regs`

## Requirements
- R1: After reset every channel's configuration reads 0x060000, its status is {EOT,TXS,RXS} = 3'b010, its enable is 0, and no DMA request or start is driven.
- R2: A configuration write stores bits 22:0 of the 32-bit write data and reads back with bits 31:23 as zero.
- R3: `cfgBad[c]` is high when channel c's word-length field (bits 11:7) is below 3 or its mode field (bits 13:12) equals 3.
- R4: A start check passes only when the channel is enabled. TXS must also be clear unless the mode is 1 (receive only). RXS must also be clear unless the mode is 2 (transmit only) or turbo (bit 19) is set.
- R5: With `singleMode` high, a channel whose force bit (bit 20) is clear never starts. Setting force allows the start.
- R6: `statusFlat[3c+2:3c]` is {EOT,TXS,RXS}. On completion, EOT and TXS are set, RXS is set unless the mode is 2, and the shifter's receive word becomes readable on `rxData`.
- R7: A transmit write loads the word, clears TXS and requests a check. A receive read clears RXS and requests a check. An enable write of 1 onto a disabled channel requests a check. No other event starts an exchange.
- R8: `shStart` is a one-cycle pulse with `shCh`, `shTxWord` (the channel's transmit word) and `shWordLen` = 1 + bits 11:7 held valid.
- R9: Only one exchange is in flight. Checks requested while busy wait until done, and the lowest-numbered waiting channel goes first.
- R10: `txDmaReq[c]` = enable & bit 14 & TXS & (mode != 1). `rxDmaReq[c]` = enable & bit 15 & RXS & (mode != 2).
- R11: In the cycle after a completion, `txEmptyEvt[c]` pulses if the mode is not 1, and `rxFullEvt[c]` pulses if the mode is not 2 and turbo is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| singleMode | input | 1 | Module single-channel mode |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrCh | input | 2 | Channel of configuration write |
| cfgWrData | input | 32 | Configuration write data |
| enWrEn | input | 1 | Enable write strobe |
| enWrCh | input | 2 | Channel of enable write |
| enWrVal | input | 1 | Enable value written |
| txWrEn | input | 1 | Transmit word write strobe |
| txWrCh | input | 2 | Channel of transmit write |
| txWrData | input | 32 | Transmit word |
| rxRdEn | input | 1 | Receive word read strobe |
| rdCh | input | 2 | Channel selected for reads |
| rxData | output | 32 | Receive word of `rdCh` |
| cfgData | output | 32 | Configuration of `rdCh` |
| statusFlat | output | 12 | {EOT,TXS,RXS} per channel |
| cfgBad | output | 4 | Illegal configuration flag per channel |
| txDmaReq | output | 4 | Transmit DMA request per channel |
| rxDmaReq | output | 4 | Receive DMA request per channel |
| txEmptyEvt | output | 4 | Transmit-empty event pulse |
| rxFullEvt | output | 4 | Receive-full event pulse |
| shStart | output | 1 | Exchange start pulse to shifter |
| shCh | output | 2 | Channel of current exchange |
| shTxWord | output | 32 | Word to shift out |
| shWordLen | output | 6 | Word length in bits |
| shDone | input | 1 | Shifter completion |
| shRxWord | input | 32 | Word shifted in |

## Verification
The hardest case to reach is a set of start checks waiting behind a busy shifter. The bench launches an exchange on channel 0 and withholds `shDone`. While it is held, transmit writes arrive on channels 3 and then 2. After done, the bench confirms that channel 2 launches before channel 3. The remaining gating cases come from a sweep over every mode, turbo setting and channel. Each sweep runs a fixed order of enable, transmit and receive actions, and a flag model in the bench predicts every start, status word and DMA request.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_BITS  = $clog2(NUM_CH);
  localparam int CFG_W    = 23;
  localparam logic [CFG_W-1:0] CFG_RESET = 23'h060000;

  // status bit positions
  localparam int ST_RXS = 0;
  localparam int ST_TXS = 1;
  localparam int ST_EOT = 2;

  // configuration field positions
  localparam int CF_WL_LO   = 7;
  localparam int CF_MODE_LO = 12;
  localparam int CF_DMA_TX  = 14;
  localparam int CF_DMA_RX  = 15;
  localparam int CF_TURBO   = 19;
  localparam int CF_FORCE   = 20;

  localparam logic [1:0] MODE_RX_ONLY = 2'd1;
  localparam logic [1:0] MODE_TX_ONLY = 2'd2;
  localparam logic [1:0] MODE_BAD     = 2'd3;

  typedef struct packed {
    logic               launch;
    logic               finish;
    logic [CH_BITS-1:0] ch;
  } seqStrobe_t;
endpackage

// File: rtl/mspi_chan_dp.sv
module mspi_chan_dp
  import mspi_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WLW = $clog2(DW) + 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWrEn,
  input  logic [CH_BITS-1:0]                cfgWrCh,
  input  logic [DW-1:0]                     cfgWrData,
  input  logic                              enWrEn,
  input  logic [CH_BITS-1:0]                enWrCh,
  input  logic                              enWrVal,
  input  logic                              txWrEn,
  input  logic [CH_BITS-1:0]                txWrCh,
  input  logic [DW-1:0]                     txWrData,
  input  logic                              rxRdEn,
  input  logic [CH_BITS-1:0]                rdCh,
  input  logic [DW-1:0]                     shRxWord,
  input  seqStrobe_t                        strobe,
  output logic [NUM_CH-1:0][CFG_W-1:0]      cfgQ,
  output logic [NUM_CH-1:0][2:0]            statQ,
  output logic [NUM_CH-1:0]                 enQ,
  output logic [DW-1:0]                     rxData,
  output logic [DW-1:0]                     cfgData,
  output logic [NUM_CH-1:0]                 cfgBad,
  output logic [NUM_CH-1:0]                 txDmaReq,
  output logic [NUM_CH-1:0]                 rxDmaReq,
  output logic [NUM_CH-1:0]                 txEmptyEvt,
  output logic [NUM_CH-1:0]                 rxFullEvt,
  output logic [DW-1:0]                     shTxWord,
  output logic [WLW-1:0]                    shWordLen
);
  logic [NUM_CH-1:0][DW-1:0] txWordQ;
  logic [NUM_CH-1:0][DW-1:0] rxWordQ;
  logic [1:0] finMode;
  logic       finTurbo;

  assign finMode  = cfgQ[strobe.ch][CF_MODE_LO +: 2];
  assign finTurbo = cfgQ[strobe.ch][CF_TURBO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cfgQ[c]    <= CFG_RESET;
        statQ[c]   <= 3'b010;
        txWordQ[c] <= '0;
        rxWordQ[c] <= '0;
      end
      enQ        <= '0;
      txEmptyEvt <= '0;
      rxFullEvt  <= '0;
      shTxWord   <= '0;
      shWordLen  <= '0;
    end else begin
      txEmptyEvt <= '0;
      rxFullEvt  <= '0;
      if (strobe.launch) begin
        shTxWord  <= txWordQ[strobe.ch];
        shWordLen <= WLW'(cfgQ[strobe.ch][CF_WL_LO +: 5]) + WLW'(1);
      end
      if (strobe.finish) begin
        statQ[strobe.ch][ST_EOT] <= 1'b1;
        statQ[strobe.ch][ST_TXS] <= 1'b1;
        if (finMode != MODE_TX_ONLY) statQ[strobe.ch][ST_RXS] <= 1'b1;
        rxWordQ[strobe.ch]    <= shRxWord;
        txEmptyEvt[strobe.ch] <= (finMode != MODE_RX_ONLY);
        rxFullEvt[strobe.ch]  <= (finMode != MODE_TX_ONLY) && !finTurbo;
      end
      if (cfgWrEn) cfgQ[cfgWrCh] <= cfgWrData[CFG_W-1:0];
      if (enWrEn)  enQ[enWrCh]   <= enWrVal;
      if (txWrEn) begin
        txWordQ[txWrCh]        <= txWrData;
        statQ[txWrCh][ST_TXS]  <= 1'b0;
      end
      if (rxRdEn) statQ[rdCh][ST_RXS] <= 1'b0;
    end
  end

  assign rxData  = rxWordQ[rdCh];
  assign cfgData = DW'(cfgQ[rdCh]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flags
    logic [1:0] mode;
    assign mode        = cfgQ[c][CF_MODE_LO +: 2];
    assign cfgBad[c]   = (cfgQ[c][CF_WL_LO +: 5] < 5'd3) || (mode == MODE_BAD);
    assign txDmaReq[c] = enQ[c] && cfgQ[c][CF_DMA_TX] && statQ[c][ST_TXS] && (mode != MODE_RX_ONLY);
    assign rxDmaReq[c] = enQ[c] && cfgQ[c][CF_DMA_RX] && statQ[c][ST_RXS] && (mode != MODE_TX_ONLY);
  end
endmodule

// File: rtl/mspi_chan_ctl.sv
module mspi_chan_ctl
  import mspi_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          singleMode,
  input  logic [NUM_CH-1:0][CFG_W-1:0]  cfgQ,
  input  logic [NUM_CH-1:0][2:0]        statQ,
  input  logic [NUM_CH-1:0]             enQ,
  input  logic                          enWrEn,
  input  logic [CH_BITS-1:0]            enWrCh,
  input  logic                          enWrVal,
  input  logic                          txWrEn,
  input  logic [CH_BITS-1:0]            txWrCh,
  input  logic                          rxRdEn,
  input  logic [CH_BITS-1:0]            rdCh,
  input  logic                          shDone,
  output seqStrobe_t                    strobe,
  output logic                          shStart,
  output logic [CH_BITS-1:0]            shCh
);
  logic [NUM_CH-1:0] trig, pendQ, ready, cand, pickOh;
  logic [CH_BITS-1:0] pickIdx;
  logic busyQ, launch, finish;

  always_comb begin
    trig = '0;
    if (txWrEn) trig[txWrCh] = 1'b1;
    if (rxRdEn) trig[rdCh]   = 1'b1;
    if (enWrEn && enWrVal && !enQ[enWrCh]) trig[enWrCh] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ready
    logic [1:0] mode;
    assign mode = cfgQ[c][CF_MODE_LO +: 2];
    assign ready[c] = enQ[c]
                   && ((mode == MODE_RX_ONLY) || !statQ[c][ST_TXS])
                   && ((mode == MODE_TX_ONLY) || cfgQ[c][CF_TURBO] || !statQ[c][ST_RXS])
                   && (!singleMode || cfgQ[c][CF_FORCE]);
  end

  assign cand = pendQ & ready;

  always_comb begin
    pickIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (cand[c]) pickIdx = CH_BITS'(c);
  end

  assign launch = !busyQ && (|cand);
  assign finish = busyQ && shDone;
  assign pickOh = launch ? (NUM_CH'(1) << pickIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      busyQ   <= 1'b0;
      shStart <= 1'b0;
      shCh    <= '0;
    end else begin
      shStart <= launch;
      if (launch) shCh <= pickIdx;
      if (busyQ) pendQ <= pendQ | trig;
      else       pendQ <= (cand & ~pickOh) | trig;
      if (launch)      busyQ <= 1'b1;
      else if (finish) busyQ <= 1'b0;
    end
  end

  assign strobe.launch = launch;
  assign strobe.finish = finish;
  assign strobe.ch     = launch ? pickIdx : shCh;
endmodule

// File: rtl/mspi_chan_regs.sv
module mspi_chan_regs
  import mspi_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WLW = $clog2(DW) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  singleMode,
  input  logic                  cfgWrEn,
  input  logic [CH_BITS-1:0]    cfgWrCh,
  input  logic [DW-1:0]         cfgWrData,
  input  logic                  enWrEn,
  input  logic [CH_BITS-1:0]    enWrCh,
  input  logic                  enWrVal,
  input  logic                  txWrEn,
  input  logic [CH_BITS-1:0]    txWrCh,
  input  logic [DW-1:0]         txWrData,
  input  logic                  rxRdEn,
  input  logic [CH_BITS-1:0]    rdCh,
  output logic [DW-1:0]         rxData,
  output logic [DW-1:0]         cfgData,
  output logic [3*NUM_CH-1:0]   statusFlat,
  output logic [NUM_CH-1:0]     cfgBad,
  output logic [NUM_CH-1:0]     txDmaReq,
  output logic [NUM_CH-1:0]     rxDmaReq,
  output logic [NUM_CH-1:0]     txEmptyEvt,
  output logic [NUM_CH-1:0]     rxFullEvt,
  output logic                  shStart,
  output logic [CH_BITS-1:0]    shCh,
  output logic [DW-1:0]         shTxWord,
  output logic [WLW-1:0]        shWordLen,
  input  logic                  shDone,
  input  logic [DW-1:0]         shRxWord
);
  seqStrobe_t strobe;
  logic [NUM_CH-1:0][CFG_W-1:0] cfgQ;
  logic [NUM_CH-1:0][2:0]       statQ;
  logic [NUM_CH-1:0]            enQ;

  assign statusFlat = statQ;

  mspi_chan_ctl u_ctl (
    .clk(clk), .rstN(rstN), .singleMode(singleMode),
    .cfgQ(cfgQ), .statQ(statQ), .enQ(enQ),
    .enWrEn(enWrEn), .enWrCh(enWrCh), .enWrVal(enWrVal),
    .txWrEn(txWrEn), .txWrCh(txWrCh), .rxRdEn(rxRdEn), .rdCh(rdCh),
    .shDone(shDone), .strobe(strobe), .shStart(shStart), .shCh(shCh)
  );

  mspi_chan_dp #(.DW(DW), .WLW(WLW)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrCh(cfgWrCh), .cfgWrData(cfgWrData),
    .enWrEn(enWrEn), .enWrCh(enWrCh), .enWrVal(enWrVal),
    .txWrEn(txWrEn), .txWrCh(txWrCh), .txWrData(txWrData),
    .rxRdEn(rxRdEn), .rdCh(rdCh), .shRxWord(shRxWord), .strobe(strobe),
    .cfgQ(cfgQ), .statQ(statQ), .enQ(enQ),
    .rxData(rxData), .cfgData(cfgData), .cfgBad(cfgBad),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt),
    .shTxWord(shTxWord), .shWordLen(shWordLen)
  );
endmodule

// File: rtl/mspi_chan_regs_chk.sv
module mspi_chan_regs_chk
  import mspi_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 shStart,
  input logic                 shDone,
  input logic [CH_BITS-1:0]   shCh,
  input logic [3*NUM_CH-1:0]  statusFlat,
  input logic [NUM_CH-1:0]    txDmaReq,
  input logic [NUM_CH-1:0]    rxDmaReq
);
  logic               inFlight;
  logic [CH_BITS-1:0] curCh;
  logic [2:0]         curStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      curCh    <= '0;
    end else if (shStart) begin
      inFlight <= !shDone;
      curCh    <= shCh;
    end else if (shDone) begin
      inFlight <= 1'b0;
    end
  end

  assign curStat = statusFlat[3*curCh +: 3];

  // R9: no second start while an exchange is outstanding
  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rstN)
    shStart |-> !inFlight);

  // R8: start is a single-cycle pulse
  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    shStart |=> !shStart);

  // R6: completion leaves end-of-transfer set on the finished channel
  assert_eot_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shDone && inFlight && !shStart) |=> curStat[ST_EOT]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dma
    // R10: DMA requests only with their flag set
    assert_txdma_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
      txDmaReq[c] |-> statusFlat[3*c + ST_TXS]);
    assert_rxdma_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
      rxDmaReq[c] |-> statusFlat[3*c + ST_RXS]);
  end
endmodule

bind mspi_chan_regs mspi_chan_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .shStart(shStart), .shDone(shDone), .shCh(shCh),
  .statusFlat(statusFlat), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
);

// File: tb/test_mspi_chan_regs.sv
`timescale 1ns/1ps
module test_mspi_chan_regs;
  logic clk = 0, rstN = 0, singleMode = 0;
  logic cfgWrEn = 0, enWrEn = 0, enWrVal = 0, txWrEn = 0, rxRdEn = 0, shDone = 0;
  logic [1:0] cfgWrCh = 0, enWrCh = 0, txWrCh = 0, rdCh = 0, shCh;
  logic [31:0] cfgWrData = 0, txWrData = 0, shRxWord = 0, rxData, cfgData, shTxWord;
  logic [11:0] statusFlat;
  logic [3:0] cfgBad, txDmaReq, rxDmaReq, txEmptyEvt, rxFullEvt;
  logic shStart;
  logic [5:0] shWordLen;
  int nChecks = 0, nFail = 0;

  always #2 clk = ~clk;

  mspi_chan_regs i_mspi_chan_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; singleMode = 0;
    cfgWrEn = 0; enWrEn = 0; txWrEn = 0; rxRdEn = 0; shDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic wrCfg(input int c, input logic [31:0] v);
    cfgWrEn = 1; cfgWrCh = 2'(c); cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic wrEn(input int c, input logic v);
    enWrEn = 1; enWrCh = 2'(c); enWrVal = v;
    @(negedge clk); enWrEn = 0;
  endtask

  task automatic wrTx(input int c, input logic [31:0] v);
    txWrEn = 1; txWrCh = 2'(c); txWrData = v;
    @(negedge clk); txWrEn = 0;
  endtask

  task automatic rdRx(input int c);
    rxRdEn = 1; rdCh = 2'(c);
    @(negedge clk); rxRdEn = 0;
  endtask

  task automatic waitStart(output bit seen);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (shStart) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finishEx(input logic [31:0] rxw);
    @(negedge clk); shDone = 1; shRxWord = rxw;
    @(negedge clk); shDone = 0;
  endtask

  task automatic runCase(input int m, input int t, input int c);
    bit en, txs, rxs, eot, seen, expStart;
    logic [31:0] cfg, lastTx, lastRx, w;
    int wl;
    doReset();
    rdCh = 2'(c);
    wl = 3 + 5 * c;
    cfg = (32'(m) << 12) | (32'(t) << 19) | (32'(c & 1) << 14) | (32'((c >> 1) & 1) << 15) | (32'(wl) << 7);
    wrCfg(c, cfg);
    en = 0; txs = 1; rxs = 0; eot = 0; lastTx = 0; lastRx = 0;
    for (int step = 0; step < 7; step++) begin
      w = 32'hA500_0000 ^ 32'((m << 8) | (t << 4) | c) ^ 32'(step << 16);
      case (step)
        0:       begin wrEn(c, 1'b1); en = 1; end
        1, 2, 4: begin wrTx(c, w); lastTx = w; txs = 0; end
        default: begin
          chk("R6 rx word", rxData, lastRx);
          rdRx(c); rxs = 0;
        end
      endcase
      expStart = en && (m == 1 || !txs) && (m == 2 || t == 1 || !rxs);
      waitStart(seen);
      chk("R4 start gate", 32'(seen), 32'(expStart));
      if (seen) begin
        chk("R8 channel", 32'(shCh), 32'(c));
        chk("R8 tx word", shTxWord, lastTx);
        chk("R8 word len", 32'(shWordLen), 32'(wl + 1));
        finishEx(~w);
        chk("R11 tx event", 32'(txEmptyEvt), (m != 1) ? (32'd1 << c) : 32'd0);
        chk("R11 rx event", 32'(rxFullEvt), (m != 2 && t == 0) ? (32'd1 << c) : 32'd0);
        lastRx = ~w; txs = 1; eot = 1;
        if (m != 2) rxs = 1;
      end
      chk("R6 status", 32'(statusFlat[3*c +: 3]), 32'({eot, txs, rxs}));
      chk("R10 tx dma", 32'(txDmaReq), (en && (c & 1) && txs && m != 1) ? (32'd1 << c) : 32'd0);
      chk("R10 rx dma", 32'(rxDmaReq), (en && ((c >> 1) & 1) && rxs && m != 2) ? (32'd1 << c) : 32'd0);
    end
  endtask

  initial begin
    bit seen;
    doReset();
    // R1 reset state, R3 flag at the reset word length
    for (int c = 0; c < 4; c++) begin
      rdCh = 2'(c); #1;
      chk("R1 config", cfgData, 32'h0006_0000);
      chk("R1 status", 32'(statusFlat[3*c +: 3]), 32'b010);
    end
    chk("R1 dma", 32'({txDmaReq, rxDmaReq}), 32'd0);
    chk("R1 start", 32'(shStart), 32'd0);
    chk("R3 reset flag", 32'(cfgBad), 32'hF);

    // R2 write masking
    wrCfg(2, 32'hFFFF_FFFF); rdCh = 2; #1;
    chk("R2 mask", cfgData, 32'h007F_FFFF);

    // R3 sweep of word length and mode fields
    for (int m = 0; m < 4; m++)
      for (int wl = 0; wl < 32; wl++) begin
        wrCfg(0, (32'(m) << 12) | (32'(wl) << 7));
        chk("R3 cfgBad", 32'(cfgBad[0]), 32'((wl < 3) || (m == 3)));
      end

    // R4 R6 R8 R10 R11 sweep over mode, turbo, channel
    for (int m = 0; m < 3; m++)
      for (int t = 0; t < 2; t++)
        for (int c = 0; c < 4; c++)
          runCase(m, t, c);

    // R7: transmit write on a disabled channel, then enable rising edge
    doReset();
    wrCfg(1, 32'(7) << 7);
    wrTx(1, 32'h1234_5678);
    waitStart(seen);
    chk("R7 disabled no start", 32'(seen), 32'd0);
    wrEn(1, 1'b1);
    waitStart(seen);
    chk("R7 enable rise start", 32'(seen), 32'd1);
    if (seen) finishEx(32'h0);
    wrEn(1, 1'b1);
    waitStart(seen);
    chk("R7 enable rewrite no start", 32'(seen), 32'd0);

    // R5 single-channel mode gating with force
    doReset();
    singleMode = 1;
    wrCfg(0, 32'(7) << 7);
    wrEn(0, 1'b1);
    wrTx(0, 32'hCAFE_0001);
    waitStart(seen);
    chk("R5 single no force", 32'(seen), 32'd0);
    wrCfg(0, (32'd1 << 20) | (32'(7) << 7));
    rdRx(0);
    waitStart(seen);
    chk("R5 single with force", 32'(seen), 32'd1);
    if (seen) finishEx(32'h0);

    // R9 hold while busy, lowest channel first
    doReset();
    for (int c = 0; c < 4; c++) begin
      wrCfg(c, (32'd2 << 12) | (32'(7) << 7));
      wrEn(c, 1'b1);
    end
    wrTx(0, 32'h0000_00A0);
    waitStart(seen);
    chk("R9 first start", 32'(seen), 32'd1);
    chk("R9 first channel", 32'(shCh), 32'd0);
    @(negedge clk);
    wrTx(3, 32'h0000_00A3);
    wrTx(2, 32'h0000_00A2);
    waitStart(seen);
    chk("R9 held while busy", 32'(seen), 32'd0);
    finishEx(32'h0);
    waitStart(seen);
    chk("R9 second start", 32'(seen), 32'd1);
    chk("R9 lowest first", 32'(shCh), 32'd2);
    chk("R9 second word", shTxWord, 32'h0000_00A2);
    finishEx(32'h0);
    waitStart(seen);
    chk("R9 third start", 32'(seen), 32'd1);
    chk("R9 third channel", 32'(shCh), 32'd3);
    finishEx(32'h0);
    chk("R6 tx-only keeps rxs clear", 32'(statusFlat[9 +: 3]), 32'b110);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule